// File: doc/BRIEF.md
# Miss Cause Classifier

This block is a tag-only model of a direct-mapped cache over 32-bit byte addresses. It is used to study access streams. Each access is looked up against the direct-mapped tags, and the block reports whether the access hit. When the access misses, the block also reports why. A miss is classed as first touch (compulsory), as an index collision (conflict) or as working-set overflow (capacity). No data is stored and no refill traffic exists: only tags, valid bits and occupancy are tracked.

Three structures answer three separate questions about the same access.

- The direct-mapped arrays decide hit or miss. A miss refills the indexed line with the new tag.
- A fully associative shadow with the same line count and least-recently-used replacement shows whether a perfectly placed cache of equal size would still hold the line.
- A bounded first-touch history shows whether the line address was ever requested since reset.

The history table has a fixed size. Once it is full, line addresses not yet recorded stay unrecorded, and the block raises a flag. That flag tells the user that later compulsory labels may be wrong.

Top module: `miss_cause_classifier`

## Requirements
- R1: Reset clears all direct-mapped valid bits, the shadow store and the history. After reset `res_valid` and `hist_full` are 0, and the first access to any address is a compulsory miss.
- R2: An access presented with `acc_valid` high at clock edge N produces `res_valid` high for exactly one cycle after edge N. A cycle with `acc_valid` low produces no result.
- R3: Address bits [3:0] are the byte offset and take no part in the lookup. Two addresses that differ only there fall in the same line.
- R4: Address bits [7:4] select one of 16 lines and bits [31:8] form a 24-bit tag. An access hits only if that line is valid and holds the same tag. A miss loads the tag and marks the line valid.
- R5: `res_class` encodes 2'b00 for a hit, 2'b01 for compulsory, 2'b10 for conflict and 2'b11 for capacity. `res_hit` is 1 exactly when the class is 2'b00.
- R6: A miss whose line address (bits [31:4]) was never requested before is compulsory. The stream 0x80000000, 0x80000008, 0x80000010, 0x80000018, 0x30000010 from reset gives compulsory, hit, compulsory, hit, compulsory.
- R7: A miss on a previously seen line that is still present in the fully associative shadow is a conflict miss. Repeating the R6 stream gives hit, hit, conflict, hit, conflict.
- R8: A miss on a previously seen line that is absent from the shadow is a capacity miss. Cycling over 17 distinct lines of one index yields capacity on every access after the first pass.
- R9: The shadow is updated on every access. A hit makes the entry most recent. A miss fills an empty entry first, and otherwise replaces the least recently used entry.
- R10: The history records up to 64 distinct line addresses in order. `hist_full` rises once 64 are recorded and stays high. After that, new line addresses are not recorded, so a re-missed unrecorded line is classed compulsory again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | 32 | Byte address of the access |
| res_valid | output | 1 | Result of the previous cycle's access |
| res_hit | output | 1 | The access hit in the direct-mapped tags |
| res_class | output | 2 | Miss class, encoding per R5 |
| hist_full | output | 1 | First-touch history has no free slot |

## Verification
The assertions assume that `acc_valid` and `acc_addr` are known and held stable around each rising edge, and that `acc_valid` is low while reset is applied. The bench changes its inputs only on falling edges and keeps `acc_valid` low through every reset. It also keeps the randomised address pool below the history size, so every compulsory label it expects comes from a correctly recorded first touch. The one exception is the history overflow case, where that is the point under test.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  typedef enum logic [1:0] {
    MC_NONE    = 2'b00,
    MC_FIRST   = 2'b01,
    MC_COLLIDE = 2'b10,
    MC_VOLUME  = 2'b11
  } miss_cls_e;

  // Priority: a direct-mapped hit wins, then first touch, then shadow presence.
  function automatic miss_cls_e classify(input logic dm_hit,
                                         input logic seen,
                                         input logic shadow_hit);
    if (dm_hit)          return MC_NONE;
    else if (!seen)      return MC_FIRST;
    else if (shadow_hit) return MC_COLLIDE;
    else                 return MC_VOLUME;
  endfunction

  function automatic int ptr_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mcc_dm_tags.sv
module mcc_dm_tags #(
  parameter int INDEX_W = 4,
  parameter int TAG_W   = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_valid,
  input  logic [INDEX_W-1:0] acc_idx,
  input  logic [TAG_W-1:0]   acc_tag,
  output logic               dm_hit
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0] line_v;
  logic [TAG_W-1:0] line_tag [LINES];

  assign dm_hit = line_v[acc_idx] && (line_tag[acc_idx] == acc_tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_v <= '0;
      for (int i = 0; i < LINES; i++) line_tag[i] <= '0;
    end else if (acc_valid && !dm_hit) begin
      line_v[acc_idx]   <= 1'b1;
      line_tag[acc_idx] <= acc_tag;
    end
  end
endmodule

// File: rtl/mcc_lru_shadow.sv
module mcc_lru_shadow #(
  parameter int LINES  = 16,
  parameter int LINE_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [LINE_W-1:0] acc_line,
  output logic              sh_hit
);
  import mcc_pkg::*;
  localparam int AGE_W = ptr_width(LINES);
  localparam int REF_W = AGE_W + 1;

  logic [LINES-1:0]  ent_v;
  logic [LINE_W-1:0] ent_line [LINES];
  logic [AGE_W-1:0]  ent_age  [LINES];

  logic [LINES-1:0] match_vec, oldest_vec;
  logic [AGE_W-1:0] hit_ptr, free_ptr, lru_ptr, tgt_ptr;
  logic             has_free;
  logic [REF_W-1:0] ref_age;

  for (genvar g = 0; g < LINES; g++) begin : g_ent
    assign match_vec[g]  = ent_v[g] && (ent_line[g] == acc_line);
    assign oldest_vec[g] = ent_v[g] && (ent_age[g] == AGE_W'(LINES - 1));
  end

  // Lowest-numbered candidate wins in each search.
  always_comb begin
    hit_ptr  = '0;
    free_ptr = '0;
    lru_ptr  = '0;
    has_free = 1'b0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (match_vec[i])  hit_ptr = AGE_W'(i);
      if (!ent_v[i]) begin
        free_ptr = AGE_W'(i);
        has_free = 1'b1;
      end
      if (oldest_vec[i]) lru_ptr = AGE_W'(i);
    end
  end

  assign sh_hit = |match_vec;

  // Entries younger than the reference age grow one step older.
  always_comb begin
    if (sh_hit) begin
      ref_age = {1'b0, ent_age[hit_ptr]};
      tgt_ptr = hit_ptr;
    end else if (has_free) begin
      ref_age = REF_W'(LINES);
      tgt_ptr = free_ptr;
    end else begin
      ref_age = REF_W'(LINES - 1);
      tgt_ptr = lru_ptr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v <= '0;
      for (int i = 0; i < LINES; i++) begin
        ent_line[i] <= '0;
        ent_age[i]  <= '0;
      end
    end else if (acc_valid) begin
      for (int i = 0; i < LINES; i++) begin
        if (AGE_W'(i) == tgt_ptr) begin
          ent_v[i]    <= 1'b1;
          ent_line[i] <= acc_line;
          ent_age[i]  <= '0;
        end else if (ent_v[i] && ({1'b0, ent_age[i]} < ref_age)) begin
          ent_age[i]  <= ent_age[i] + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mcc_first_touch.sv
module mcc_first_touch #(
  parameter int DEPTH  = 64,
  parameter int LINE_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [LINE_W-1:0] acc_line,
  output logic              seen,
  output logic              full
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [LINE_W-1:0] hist_line [DEPTH];
  logic [CNT_W-1:0]  hist_cnt;
  logic [DEPTH-1:0]  hit_vec;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign hit_vec[g] = (CNT_W'(g) < hist_cnt) && (hist_line[g] == acc_line);
  end

  assign seen = |hit_vec;
  assign full = (hist_cnt == CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist_cnt <= '0;
      for (int i = 0; i < DEPTH; i++) hist_line[i] <= '0;
    end else if (acc_valid && !seen && !full) begin
      for (int i = 0; i < DEPTH; i++)
        if (CNT_W'(i) == hist_cnt) hist_line[i] <= acc_line;
      hist_cnt <= hist_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/miss_cause_classifier.sv
module miss_cause_classifier #(
  parameter int ADDR_W     = 32,
  parameter int OFFSET_W   = 4,
  parameter int INDEX_W    = 4,
  parameter int HIST_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              res_valid,
  output logic              res_hit,
  output logic [1:0]        res_class,
  output logic              hist_full
);
  import mcc_pkg::*;
  localparam int LINES  = 1 << INDEX_W;
  localparam int LINE_W = ADDR_W - OFFSET_W;
  localparam int TAG_W  = LINE_W - INDEX_W;

  logic [LINE_W-1:0]  acc_line;
  logic [INDEX_W-1:0] acc_idx;
  logic [TAG_W-1:0]   acc_tag;
  logic               offset_unused;
  logic               dm_hit, seen_hit, shadow_hit;
  miss_cls_e          cls_now;

  assign acc_line      = acc_addr[ADDR_W-1:OFFSET_W];
  assign acc_idx       = acc_line[INDEX_W-1:0];
  assign acc_tag       = acc_line[LINE_W-1:INDEX_W];
  assign offset_unused = ^acc_addr[OFFSET_W-1:0];

  mcc_dm_tags #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) dm_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
    .acc_idx(acc_idx), .acc_tag(acc_tag), .dm_hit(dm_hit)
  );

  mcc_lru_shadow #(.LINES(LINES), .LINE_W(LINE_W)) shadow_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
    .acc_line(acc_line), .sh_hit(shadow_hit)
  );

  mcc_first_touch #(.DEPTH(HIST_DEPTH), .LINE_W(LINE_W)) hist_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
    .acc_line(acc_line), .seen(seen_hit), .full(hist_full)
  );

  assign cls_now = classify(dm_hit, seen_hit, shadow_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_class <= MC_NONE;
    end else begin
      res_valid <= acc_valid;
      if (acc_valid) begin
        res_hit   <= dm_hit;
        res_class <= cls_now;
      end
    end
  end
endmodule

// File: rtl/mcc_checker.sv
module mcc_checker #(
  parameter int LINE_W = 28
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic [LINE_W-1:0] acc_line,
  input logic              res_valid,
  input logic              res_hit,
  input logic [1:0]        res_class,
  input logic              hist_full,
  input logic              dm_hit,
  input logic              seen_hit
);
  a_r2_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> res_valid);

  a_r2_no_idle_result: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !res_valid);

  a_r4_repeat_line_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && $past(acc_valid) && $past(rst_n) && acc_line == $past(acc_line)) |-> dm_hit);

  a_r5_hit_flag_class: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_hit == (res_class == 2'b00)));

  a_r6_hit_was_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && dm_hit && !hist_full) |-> seen_hit);

  a_r10_full_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    hist_full |=> hist_full);
endmodule

bind miss_cause_classifier mcc_checker #(.LINE_W(LINE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_line(acc_line),
  .res_valid(res_valid), .res_hit(res_hit), .res_class(res_class),
  .hist_full(hist_full), .dm_hit(dm_hit), .seen_hit(seen_hit)
);

// File: tb/miss_cause_classifier_tb_top.sv
`timescale 1ns/1ps
module miss_cause_classifier_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic res_valid, res_hit, hist_full;
  logic [1:0] res_class;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [1:0] last_cls;

  always #10 clk = ~clk;

  miss_cause_classifier dut_i (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_class(res_class),
    .hist_full(hist_full)
  );

  // Behavioural reference: per-index tag list, recency queue, first-touch list.
  logic [23:0] m_tag [16];
  bit          m_v   [16];
  logic [27:0] m_recent [$];
  logic [27:0] m_hist   [$];

  task automatic model_reset();
    for (int i = 0; i < 16; i++) begin m_v[i] = 0; m_tag[i] = '0; end
    m_recent.delete();
    m_hist.delete();
  endtask

  task automatic model_step(input logic [31:0] a, output logic [1:0] cls);
    logic [27:0] ln;
    bit seen, inrec, hit;
    int pos;
    ln = a[31:4];
    hit = m_v[a[7:4]] && (m_tag[a[7:4]] == a[31:8]);
    seen = 0;
    foreach (m_hist[k]) if (m_hist[k] == ln) seen = 1;
    inrec = 0; pos = 0;
    foreach (m_recent[k]) if (m_recent[k] == ln) begin inrec = 1; pos = k; end
    if (hit) cls = 2'b00;
    else if (!seen) cls = 2'b01;
    else if (inrec) cls = 2'b10;
    else cls = 2'b11;
    m_v[a[7:4]] = 1; m_tag[a[7:4]] = a[31:8];
    if (inrec) m_recent.delete(pos);
    else if (m_recent.size() == 16) void'(m_recent.pop_back());
    m_recent.push_front(ln);
    if (!seen && m_hist.size() < 64) m_hist.push_back(ln);
  endtask

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    acc_valid = 0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
    check(res_valid == 0, "R1 res_valid after reset", {31'b0, res_valid}, 0);
    check(hist_full == 0, "R1 hist_full after reset", {31'b0, hist_full}, 0);
  endtask

  // Drive at a falling edge, sample at the next falling edge (one register).
  task automatic acc(input logic [31:0] a, input string rq);
    logic [1:0] ec;
    model_step(a, ec);
    acc_valid = 1;
    acc_addr  = a;
    @(negedge clk);
    last_cls = res_class;
    check(res_valid == 1, {rq, " R2 res_valid"}, {31'b0, res_valid}, 1);
    check(res_class == ec && res_hit == (ec == 2'b00), {rq, " R5 class/hit vs model"},
          {29'b0, res_hit, res_class}, {29'b0, ec == 2'b00, ec});
    acc_valid = 0;
  endtask

  task automatic expect_cls(input logic [1:0] e, input string rq);
    check(last_cls == e, rq, {30'b0, last_cls}, {30'b0, e});
  endtask

  logic [31:0] seq [5] = '{32'h80000000, 32'h80000008, 32'h80000010, 32'h80000018, 32'h30000010};
  logic [1:0]  ex1 [5] = '{2'b01, 2'b00, 2'b01, 2'b00, 2'b01};
  logic [1:0]  ex2 [5] = '{2'b00, 2'b00, 2'b10, 2'b00, 2'b10};

  initial begin
    model_reset();
    do_reset();

    // R6 / R7: the reference stream, twice.
    for (int i = 0; i < 5; i++) begin acc(seq[i], "R6"); expect_cls(ex1[i], "R6 first pass"); end
    for (int i = 0; i < 5; i++) begin acc(seq[i], "R7"); expect_cls(ex2[i], "R7 second pass"); end

    // R2: idle cycle gives no result.
    @(negedge clk);
    check(res_valid == 0, "R2 idle no result", {31'b0, res_valid}, 0);

    // R3: offset bits do not matter.
    acc(32'h1234567F, "R3"); expect_cls(2'b01, "R3 first");
    acc(32'h12345670, "R3"); expect_cls(2'b00, "R3 same line other offset");

    // R1: reset forgets everything.
    do_reset();
    acc(32'h80000000, "R1"); expect_cls(2'b01, "R1 compulsory after reset");

    // R9: recency refresh on hit spares L0 from shadow eviction.
    do_reset();
    for (int i = 0; i < 16; i++) acc(32'h40000000 | (i << 4), "R9 fill");
    acc(32'h40000000, "R9"); expect_cls(2'b00, "R4 R9 refresh hit");
    acc(32'h50000000, "R9"); expect_cls(2'b01, "R9 new line idx0");
    acc(32'h40000000, "R9"); expect_cls(2'b10, "R9 refreshed line still in shadow");
    acc(32'h40000010, "R9"); expect_cls(2'b00, "R4 other index untouched");

    // R8: 17 lines on one index, cycled.
    do_reset();
    for (int p = 0; p < 3; p++)
      for (int i = 0; i < 17; i++) begin
        acc(32'h07000000 + (i << 8), "R8");
        expect_cls(p == 0 ? 2'b01 : 2'b11, "R8 sweep");
      end

    // Near-exhaustive random over 3 tags x 8 indexes.
    do_reset();
    begin
      logic [15:0] lf = 16'hACE1;
      for (int n = 0; n < 600; n++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        acc({6'd0, 2'(lf[1:0] % 3), 16'h0, lf[5:3], 1'b0, lf[9:6]}, "R4 R7 R8 R9 random");
      end
    end

    // R10: history fills after 64 distinct lines.
    do_reset();
    for (int i = 0; i < 63; i++) acc(i << 4, "R10 fill");
    check(hist_full == 0, "R10 not full at 63", {31'b0, hist_full}, 0);
    acc(63 << 4, "R10 fill");
    check(hist_full == 1, "R10 full at 64", {31'b0, hist_full}, 1);
    acc(32'h10000000, "R10"); expect_cls(2'b01, "R10 new line");
    acc(32'h20000000, "R10"); expect_cls(2'b01, "R10 new line");
    acc(32'h10000000, "R10"); expect_cls(2'b01, "R10 unrecorded line again compulsory");
    check(hist_full == 1, "R10 stays full", {31'b0, hist_full}, 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule